// File: doc/BRIEF.md
# PAL Line Timing Controller

This block sequences one horizontal line of a PAL composite video signal, one clock per DAC sample tick (nominally 141.6 MHz, about 7.06 ns). Each line opens with a one-cycle select state. In that state the line either starts, or the controller waits with the output at sync level. A started line drives the sync level, then a first back porch at black level. It then hands the output to an external sample serializer, which delivers the colour burst, the second back porch and the active picture as a stream of 4-bit DAC codes. When the serializer marks its last stream cycle, the controller drives a black front porch and returns straight to the select state.

The serializer is started by a one-cycle pulse in the final back-porch cycle, so it can present its first sample on the following cycle. A line-start interrupt is pulsed in the select cycle that begins each line. A line counter measures every line from the select cycle to the last front-porch cycle. It flags any line whose length differs from the configured total, which by default is 9062 clocks (283.75 colour-carrier cycles). The default segment lengths are 672 sync cycles, 138 first-back-porch cycles and 234 front-porch cycles. These leave 8018 cycles for the streamed region.

Top module: `pal_line_ctrl`

## Requirements
- R1: While reset is held, dac_out is 0 (sync level) and line_irq, stream_go and len_err are all 0.
- R2: In the select state with draw_req low, no line starts: dac_out stays 0, no interrupt is raised, and stream_level and stream_done have no effect on the outputs.
- R3: In the select state with draw_req high, line_irq is 1 for exactly that cycle and dac_out is 0.
- R4: The sync level (code 0) lasts SYNC_LEN cycles in total, counting the select cycle that starts the line.
- R5: After sync, dac_out holds black level (code 4) for BP0_LEN cycles.
- R6: stream_go is 1 for exactly one cycle per line, which is the last first-back-porch cycle.
- R7: From the cycle after the last back-porch cycle, up to and including the cycle in which stream_done is 1, dac_out equals stream_level in the same cycle.
- R8: stream_done has no effect outside the streamed region, and draw_req has no effect outside the select state.
- R9: After the stream_done cycle, dac_out holds black level (code 4) for FP_LEN cycles. The next cycle is the select state, with no idle cycle, so a line can follow at once.
- R10: len_err is 1 in the last front-porch cycle exactly when the line length from select cycle to last front-porch cycle differs from LINE_LEN, and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| draw_req | input | 1 | Start a line when sampled in the select state |
| stream_level | input | 4 | DAC code from the sample serializer |
| stream_done | input | 1 | Serializer's last stream cycle of the line |
| dac_out | output | 4 | DAC code driven to the converter |
| line_irq | output | 1 | One-cycle pulse at the start of each line |
| stream_go | output | 1 | One-cycle start pulse for the serializer |
| len_err | output | 1 | Line length mismatch, valid in the last front-porch cycle |

## Verification
Lines are run with the streamed region at exactly the nominal length, one cycle short, one cycle long, a single cycle, far longer than the line, and at random lengths. The length flag must separate the nominal line from every other length, and the level sequence must hold its shape whatever the stream length. Random stream codes during the streamed region tell a true pass-through apart from a fixed level. Spurious stream_done pulses and toggling draw_req are injected during sync, back porch, front porch and idle select cycles, so that a controller reacting outside its own window shows up as a broken sequence. Lines are run back to back, so an extra idle cycle after the front porch appears as a missing interrupt.

// File: rtl/pal_line_pkg.sv
package pal_line_pkg;

    localparam int DAC_W = 4;

    localparam logic [DAC_W-1:0] LVL_SYNC  = 4'd0;
    localparam logic [DAC_W-1:0] LVL_BLACK = 4'd4;

    typedef enum logic [2:0] {
        SEG_SELECT,
        SEG_SYNC,
        SEG_PORCH_A,
        SEG_STREAM,
        SEG_PORCH_F
    } seg_e;

    typedef struct packed {
        seg_e seg;
        logic last;
    } seg_info_t;

    function automatic logic [DAC_W-1:0] fixed_level(seg_e s);
        if (s == SEG_PORCH_A || s == SEG_PORCH_F)
            return LVL_BLACK;
        return LVL_SYNC;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pal_seg_fsm.sv
module pal_seg_fsm
    import pal_line_pkg::*;
#(
    parameter int SYNC_LEN = 672,
    parameter int BP0_LEN  = 138,
    parameter int FP_LEN   = 234
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      draw_req,
    input  logic      stream_done,
    output seg_info_t info,
    output logic      line_irq,
    output logic      stream_go
);
    localparam int MAXL = max3(SYNC_LEN, BP0_LEN, FP_LEN);
    localparam int CW   = $clog2(MAXL + 1);

    seg_e          seg;
    logic [CW-1:0] cnt;
    logic          cnt_zero;

    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            seg <= SEG_SELECT;
            cnt <= '0;
        end else begin
            case (seg)
                SEG_SELECT: begin
                    if (draw_req) begin
                        seg <= SEG_SYNC;
                        cnt <= CW'(SYNC_LEN - 2);
                    end
                end
                SEG_SYNC: begin
                    if (cnt_zero) begin
                        seg <= SEG_PORCH_A;
                        cnt <= CW'(BP0_LEN - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SEG_PORCH_A: begin
                    if (cnt_zero) begin
                        seg <= SEG_STREAM;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SEG_STREAM: begin
                    if (stream_done) begin
                        seg <= SEG_PORCH_F;
                        cnt <= CW'(FP_LEN - 1);
                    end
                end
                SEG_PORCH_F: begin
                    if (cnt_zero) begin
                        seg <= SEG_SELECT;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    seg <= SEG_SELECT;
                    cnt <= '0;
                end
            endcase
        end
    end

    assign info.seg  = seg;
    assign info.last = cnt_zero && (seg != SEG_SELECT) && (seg != SEG_STREAM);
    assign line_irq  = (seg == SEG_SELECT) && draw_req;
    assign stream_go = (seg == SEG_PORCH_A) && cnt_zero;

    AST_IRQ_OPENS_SYNC: assert property (@(posedge clk) disable iff (rst)
        line_irq |=> (seg == SEG_SYNC)); // R3

    AST_GO_OPENS_STREAM: assert property (@(posedge clk) disable iff (rst)
        stream_go |=> (seg == SEG_STREAM)); // R6

    AST_PORCH_A_AFTER_SYNC: assert property (@(posedge clk) disable iff (rst)
        (seg == SEG_PORCH_A && $past(seg) != SEG_PORCH_A) |-> ($past(seg) == SEG_SYNC)); // R5

    AST_SELECT_AFTER_PORCH_F: assert property (@(posedge clk) disable iff (rst)
        (seg == SEG_SELECT && $past(seg) != SEG_SELECT) |-> ($past(seg) == SEG_PORCH_F)); // R9

endmodule

// File: rtl/pal_line_meter.sv
module pal_line_meter #(
    parameter int LINE_LEN = 9062
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    input  logic line_end,
    output logic len_err
);
    localparam int LW = $clog2(LINE_LEN + 1) + 1;
    localparam logic [LW:0] LINE_TGT = (LW + 1)'(LINE_LEN);

    logic [LW-1:0] line_cnt;
    logic          sat;

    assign sat = &line_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt <= '0;
        end else if (start) begin
            line_cnt <= LW'(1);
        end else if (active && !sat) begin
            line_cnt <= line_cnt + 1'b1;
        end
    end

    assign len_err = line_end && (({1'b0, line_cnt} + 1'b1) != LINE_TGT);

    AST_ERR_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        len_err |-> line_end); // R10

endmodule

// File: rtl/pal_level_mux.sv
module pal_level_mux
    import pal_line_pkg::*;
(
    input  seg_e             seg,
    input  logic [DAC_W-1:0] stream_level,
    output logic [DAC_W-1:0] dac_out
);
    always_comb begin
        if (seg == SEG_STREAM)
            dac_out = stream_level;
        else
            dac_out = fixed_level(seg);
    end
endmodule

// File: rtl/pal_line_ctrl.sv
module pal_line_ctrl
    import pal_line_pkg::*;
#(
    parameter int SYNC_LEN = 672,
    parameter int BP0_LEN  = 138,
    parameter int FP_LEN   = 234,
    parameter int LINE_LEN = 9062
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       draw_req,
    input  logic [3:0] stream_level,
    input  logic       stream_done,
    output logic [3:0] dac_out,
    output logic       line_irq,
    output logic       stream_go,
    output logic       len_err
);
    seg_info_t info;

    pal_seg_fsm #(
        .SYNC_LEN(SYNC_LEN),
        .BP0_LEN (BP0_LEN),
        .FP_LEN  (FP_LEN)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .draw_req   (draw_req),
        .stream_done(stream_done),
        .info       (info),
        .line_irq   (line_irq),
        .stream_go  (stream_go)
    );

    pal_line_meter #(
        .LINE_LEN(LINE_LEN)
    ) u_meter (
        .clk     (clk),
        .rst     (rst),
        .start   (line_irq),
        .active  (info.seg != SEG_SELECT),
        .line_end(info.last && info.seg == SEG_PORCH_F),
        .len_err (len_err)
    );

    pal_level_mux u_mux (
        .seg         (info.seg),
        .stream_level(stream_level),
        .dac_out     (dac_out)
    );

    AST_BLACK_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (info.seg == SEG_STREAM && stream_done) |=> (dac_out == LVL_BLACK)); // R9

    AST_IRQ_AT_SYNC_LEVEL: assert property (@(posedge clk) disable iff (rst)
        line_irq |-> (dac_out == LVL_SYNC)); // R3

    AST_GO_AT_BLACK: assert property (@(posedge clk) disable iff (rst)
        stream_go |-> (dac_out == LVL_BLACK && !line_irq)); // R6

endmodule

// File: tb/tb_pal_line_ctrl.sv
module tb_pal_line_ctrl;
    localparam int CLK_PERIOD = 8;
    localparam int T_SYNC = 12;
    localparam int T_BP0  = 7;
    localparam int T_FP   = 9;
    localparam int T_LINE = 60;
    localparam int T_NOM  = T_LINE - T_SYNC - T_BP0 - T_FP;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       draw_req = 1'b0;
    logic [3:0] stream_level = 4'd0;
    logic       stream_done = 1'b0;
    logic [3:0] dac_out;
    logic       line_irq;
    logic       stream_go;
    logic       len_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    pal_line_ctrl #(
        .SYNC_LEN(T_SYNC),
        .BP0_LEN (T_BP0),
        .FP_LEN  (T_FP),
        .LINE_LEN(T_LINE)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .draw_req    (draw_req),
        .stream_level(stream_level),
        .stream_done (stream_done),
        .dac_out     (dac_out),
        .line_irq    (line_irq),
        .stream_go   (stream_go),
        .len_err     (len_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic bit exp_len_err(int s);
        return (T_SYNC + T_BP0 + s + T_FP) != T_LINE;
    endfunction

    task automatic check(string req, logic [3:0] e_dac, logic e_irq, logic e_go, logic e_err);
        checks++;
        if ({dac_out, line_irq, stream_go, len_err} !== {e_dac, e_irq, e_go, e_err}) begin
            errors++;
            $display("FAIL %s t=%0t: dac/irq/go/err actual %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
                     req, $time, dac_out, line_irq, stream_go, len_err,
                     e_dac, e_irq, e_go, e_err);
        end
    endtask

    task automatic run_line(int s, bit noise);
        // select cycle starts the line (R3)
        draw_req = 1'b1;
        stream_done = noise ? 1'($urandom) : 1'b0;
        stream_level = 4'($urandom);
        #1 check("R3", 4'd0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        for (int i = 1; i < T_SYNC; i++) begin
            draw_req = noise ? 1'($urandom) : 1'b0;
            stream_done = noise ? 1'($urandom) : 1'b0;
            stream_level = 4'($urandom);
            #1 check("R4/R8", 4'd0, 1'b0, 1'b0, 1'b0);
            @(negedge clk);
        end
        for (int j = 0; j < T_BP0; j++) begin
            draw_req = noise ? 1'($urandom) : 1'b0;
            stream_done = noise ? 1'($urandom) : 1'b0;
            stream_level = 4'($urandom);
            #1 check((j == T_BP0 - 1) ? "R6" : "R5", 4'd4, 1'b0, (j == T_BP0 - 1), 1'b0);
            @(negedge clk);
        end
        for (int k = 0; k < s; k++) begin
            draw_req = noise ? 1'($urandom) : 1'b0;
            stream_done = (k == s - 1);
            stream_level = 4'($urandom);
            #1 check("R7", stream_level, 1'b0, 1'b0, 1'b0);
            @(negedge clk);
        end
        for (int m = 0; m < T_FP; m++) begin
            draw_req = noise ? 1'($urandom) : 1'b0;
            stream_done = noise ? 1'($urandom) : 1'b0;
            stream_level = 4'($urandom);
            #1 check((m == T_FP - 1) ? "R10" : "R9", 4'd4, 1'b0, 1'b0,
                     (m == T_FP - 1) && exp_len_err(s));
            @(negedge clk);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            draw_req = 1'b0;
            stream_done = 1'($urandom);
            stream_level = 4'($urandom);
            #1 check("R2", 4'd0, 1'b0, 1'b0, 1'b0);
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1 check("R1", 4'd0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        idle(6);
        // directed lengths around the nominal stream region
        run_line(T_NOM, 1'b0);
        run_line(T_NOM, 1'b1);
        run_line(T_NOM - 1, 1'b1);
        run_line(T_NOM + 1, 1'b1);
        run_line(1, 1'b1);
        idle(4);
        run_line(700, 1'b1);
        // random lengths, back to back (R9: no idle cycle between lines)
        for (int r = 0; r < 12; r++) begin
            run_line(1 + int'($urandom_range(0, 63)), 1'b1);
        end
        idle(3);
        run_line(T_NOM, 1'b1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule